// File: doc/BRIEF.md
# Single-Wire Register Write Receiver

This block is the device end of a one-wire, write-only control link. A fast local clock samples the line. Long static levels on the line act as power commands. A high level held long enough wakes the block from the disabled state into sleep. A low level held long enough shuts it down and restores every register to its reset value.

While the block is enabled, each write transaction opens with two low/high preamble pairs. Each half of a pair lasts one bit time. The block uses the second pair to learn the host's bit period. A low start bit comes next, then a register address, then a data byte. The block samples each address and data bit in the middle of its bit window. When the last bit is in, it pulses a write strobe and updates one entry of a 32-entry register bank. The host must then hold the line high for five bit times before it starts another write.

Top module: `swire_rx`

## Requirements
- R1: After the synchronised line has been high for `EN_CYC` consecutive cycles, the block moves from disabled (`state` = 2'b00) to sleep (`state` = 2'b01). Shorter high periods leave it disabled.
- R2: After the synchronised line has been low for `DIS_CYC` consecutive cycles, the block moves to disabled from any state.
- R3: While disabled, no transaction is decoded, `wr_stb` stays low and the registers do not change. This holds until R1 enables the block again.
- R4: At reset and on every shutdown, all register bits read zero except bit `FLT_BIT` of register `FLT_ADDR`, which reads one. Register n sits at `regs[n*8 +: 8]`.
- R5: The bit period is learned anew from every transaction's second low/high pair. Writes decode correctly at any bit period from 20 up to `MAX_BIT_CYC` clock cycles.
- R6: The 5 address bits follow the low start bit, most significant bit first, and appear on `wr_addr`.
- R7: The 8 data bits follow the address, most significant bit first. They appear on `wr_data` and are stored in the addressed register, including the fault register.
- R8: `wr_stb` is high for exactly one cycle per completed transaction. The register shows the new value from the next cycle on.
- R9: `state` reads active (2'b10) from the first preamble edge until the line has been high for five learned bit times after the last data bit. After that it returns to sleep.
- R10: `state` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least 20 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin | input | 1 | Raw line from the host |
| state | output | 2 | 00 disabled, 01 sleep, 10 active |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 5 | Address of the write under the strobe |
| wr_data | output | 8 | Data of the write under the strobe |
| regs | output | 256 | Register bank contents, register n at bits n*8 +: 8 |

## Verification
On every cycle, the assertions check these properties:
- the strobe is a single pulse;
- a strobed byte lands in the addressed register;
- the disabled state always shows default contents and never strobes;
- leaving the disabled state always goes to sleep;
- the state code stays legal.

Other behaviour only the bench scenarios can show, because it depends on the line history:
- the bit-order decoding;
- learning of different bit periods;
- the exact enable and shutdown thresholds;
- the five-bit-time guard;
- frames ignored while disabled.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [1:0] {
    PWR_OFF    = 2'b00,
    PWR_SLEEP  = 2'b01,
    PWR_ACTIVE = 2'b10
  } pwr_e;

  typedef enum logic [2:0] {
    D_IDLE,
    D_WAKE_LO,
    D_WAKE_HI,
    D_MEAS_LO,
    D_MEAS_HI,
    D_BITS,
    D_GUARD
  } dec_e;
endpackage

// File: rtl/swr_level_timer.sv
// Synchronises the line and flags long static levels.
module swr_level_timer #(
  parameter int EN_CYC  = 250000,
  parameter int DIS_CYC = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic s,
  output logic en_hit,
  output logic dis_hit
);
  localparam int LIM = (EN_CYC > DIS_CYC) ? EN_CYC : DIS_CYC;
  localparam int RW  = $clog2(LIM + 1);

  logic          sync1_q, sync2_q, s_d_q;
  logic [RW-1:0] run_q, run_n;
  logic          steady;

  assign steady = (sync2_q == s_d_q);

  always_comb begin
    run_n = run_q;
    if (!steady)
      run_n = '0;
    else if (run_q != RW'(LIM))
      run_n = run_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      s_d_q   <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      s_d_q   <= sync2_q;
      run_q   <= run_n;
    end
  end

  assign s       = sync2_q;
  assign en_hit  = steady &  sync2_q & (run_q == RW'(EN_CYC - 1));
  assign dis_hit = steady & ~sync2_q & (run_q == RW'(DIS_CYC - 1));
endmodule

// File: rtl/swr_frame_dec.sv
// Preamble measurement, mid-bit sampling and post-frame guard.
module swr_frame_dec
  import swr_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          s,
  output logic          busy,
  output logic          stb,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int NB  = AW + DW;
  localparam int BCW = $clog2(NB + 1);

  dec_e           st_q, st_n;
  logic           s_d_q;
  logic [CW-1:0]  cnt_q, cnt_n, per_q, per_n, tgt_q, tgt_n;
  logic [CW-1:0]  cnt_inc, guard_lim;
  logic [NB-1:0]  sh_q, sh_n;
  logic [BCW-1:0] nb_q, nb_n;
  logic           stb_q, stb_n;
  logic           fall, rise;

  assign fall      = s_d_q & ~s;
  assign rise      = ~s_d_q & s;
  assign cnt_inc   = (&cnt_q) ? cnt_q : cnt_q + CW'(1);
  assign guard_lim = (per_q << 2) + per_q - CW'(1);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_inc;
    per_n = per_q;
    tgt_n = tgt_q;
    sh_n  = sh_q;
    nb_n  = nb_q;
    stb_n = 1'b0;
    case (st_q)
      D_IDLE: begin
        cnt_n = '0;
        if (fall) st_n = D_WAKE_LO;
      end
      D_WAKE_LO: if (rise) st_n = D_WAKE_HI;
      D_WAKE_HI: begin
        if (fall) begin
          st_n  = D_MEAS_LO;
          cnt_n = '0;
        end
      end
      D_MEAS_LO: if (rise) st_n = D_MEAS_HI;
      D_MEAS_HI: begin
        if (fall) begin
          // cnt_inc spans two bit periods here
          st_n  = D_BITS;
          per_n = cnt_inc >> 1;
          tgt_n = (cnt_inc >> 1) + (cnt_inc >> 2) - CW'(1);
          cnt_n = '0;
          nb_n  = '0;
        end
      end
      D_BITS: begin
        if (cnt_q == tgt_q) begin
          sh_n  = {sh_q[NB-2:0], s};
          nb_n  = nb_q + BCW'(1);
          cnt_n = '0;
          tgt_n = per_q - CW'(1);
          if (nb_q == BCW'(NB - 1)) begin
            st_n  = D_GUARD;
            stb_n = 1'b1;
          end
        end
      end
      D_GUARD: begin
        cnt_n = s ? cnt_inc : '0;
        if (s && (cnt_q == guard_lim)) st_n = D_IDLE;
      end
      default: st_n = D_IDLE;
    endcase
    if (!run_en) begin
      st_n  = D_IDLE;
      stb_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= D_IDLE;
      s_d_q <= 1'b0;
      cnt_q <= '0;
      per_q <= '0;
      tgt_q <= '0;
      sh_q  <= '0;
      nb_q  <= '0;
      stb_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      s_d_q <= s;
      cnt_q <= cnt_n;
      per_q <= per_n;
      tgt_q <= tgt_n;
      sh_q  <= sh_n;
      nb_q  <= nb_n;
      stb_q <= stb_n;
    end
  end

  assign busy = (st_q != D_IDLE);
  assign stb  = stb_q;
  assign addr = sh_q[NB-1:DW];
  assign data = sh_q[DW-1:0];
endmodule

// File: rtl/swr_regbank.sv
// Register bank with one default-set fault bit.
module swr_regbank #(
  parameter int NREG     = 32,
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int FLT_ADDR = 1,
  parameter int FLT_BIT  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] RST = (g == FLT_ADDR) ? (DW'(1) << FLT_BIT) : '0;
    logic [DW-1:0] r_q, r_n;

    always_comb begin
      r_n = r_q;
      if (clr)
        r_n = RST;
      else if (we && (waddr == AW'(g)))
        r_n = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= RST;
      else        r_q <= r_n;
    end

    assign regs[g*DW +: DW] = r_q;
  end
endmodule

// File: rtl/swire_rx.sv
module swire_rx
  import swr_pkg::*;
#(
  parameter int NREG        = 32,
  parameter int DW          = 8,
  parameter int EN_CYC      = 250000,
  parameter int DIS_CYC     = 2500000,
  parameter int MAX_BIT_CYC = 4095,
  parameter int FLT_ADDR    = 1,
  parameter int FLT_BIT     = 0,
  localparam int AW         = $clog2(NREG),
  localparam int CW         = $clog2(6 * MAX_BIT_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin,
  output logic [1:0]         state,
  output logic               wr_stb,
  output logic [AW-1:0]      wr_addr,
  output logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs
);
  logic s, en_hit, dis_hit, busy, run_en;
  logic en_q, en_n;
  pwr_e pwr;

  swr_level_timer #(.EN_CYC(EN_CYC), .DIS_CYC(DIS_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .pin(pin),
    .s(s), .en_hit(en_hit), .dis_hit(dis_hit)
  );

  always_comb begin
    en_n = en_q;
    if (dis_hit)     en_n = 1'b0;
    else if (en_hit) en_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_n;
  end

  assign run_en = en_q & ~dis_hit;

  swr_frame_dec #(.AW(AW), .DW(DW), .CW(CW)) u_dec (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .s(s),
    .busy(busy), .stb(wr_stb), .addr(wr_addr), .data(wr_data)
  );

  swr_regbank #(
    .NREG(NREG), .DW(DW), .AW(AW), .FLT_ADDR(FLT_ADDR), .FLT_BIT(FLT_BIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(dis_hit), .we(wr_stb & en_q),
    .waddr(wr_addr), .wdata(wr_data), .regs(regs)
  );

  always_comb begin
    if (!en_q)     pwr = PWR_OFF;
    else if (busy) pwr = PWR_ACTIVE;
    else           pwr = PWR_SLEEP;
  end

  assign state = pwr;
endmodule

// File: rtl/swr_checker.sv
module swr_checker #(
  parameter int NREG     = 32,
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int FLT_ADDR = 1,
  parameter int FLT_BIT  = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         state,
  input logic               wr_stb,
  input logic [AW-1:0]      wr_addr,
  input logic [DW-1:0]      wr_data,
  input logic [NREG*DW-1:0] regs
);
  function automatic logic [NREG*DW-1:0] defaults();
    logic [NREG*DW-1:0] v;
    v = '0;
    v[FLT_ADDR*DW + FLT_BIT] = 1'b1;
    return v;
  endfunction

  localparam logic [NREG*DW-1:0] DEF = defaults();

  logic          stb_d;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_d <= 1'b0;
      a_q   <= '0;
      d_q   <= '0;
    end else begin
      stb_d <= wr_stb;
      a_q   <= wr_addr;
      d_q   <= wr_data;
    end
  end

  assign rd = DW'(regs >> (a_q * DW));

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    stb_d |-> (state == 2'b00) || (rd == d_q)); // R7
  AST_OFF_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b00) |-> (regs == DEF)); // R4
  AST_OFF_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b00) |-> !wr_stb); // R3
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11); // R10
  AST_WAKE_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'b00 && state != 2'b00) |-> (state == 2'b01)); // R1
endmodule

bind swire_rx swr_checker #(
  .NREG(NREG), .DW(DW), .AW(AW), .FLT_ADDR(FLT_ADDR), .FLT_BIT(FLT_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .wr_stb(wr_stb),
  .wr_addr(wr_addr), .wr_data(wr_data), .regs(regs)
);

// File: tb/sim_swire_rx.sv
module sim_swire_rx;
  localparam int NREG = 32;
  localparam int DW   = 8;
  localparam int AW   = 5;
  localparam int EN   = 400;
  localparam int DIS  = 2000;
  localparam int FLT_ADDR = 1;

  logic               clk, rst_n, pin;
  logic [1:0]         state;
  logic               wr_stb;
  logic [AW-1:0]      wr_addr;
  logic [DW-1:0]      wr_data;
  logic [NREG*DW-1:0] regs;

  swire_rx #(.EN_CYC(EN), .DIS_CYC(DIS), .MAX_BIT_CYC(255)) u0 (
    .clk(clk), .rst_n(rst_n), .pin(pin), .state(state), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .regs(regs)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0, mon_on = 0;
  logic [12:0]   exp_q[$];
  logic [DW-1:0] shadow[NREG];
  bit            pend = 0;
  int            pa, bad;
  logic [DW-1:0] pd;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic void shadow_defaults();
    for (int i = 0; i < NREG; i++) shadow[i] = (i == FLT_ADDR) ? 8'h01 : 8'h00;
  endfunction

  // Reference model compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (pend) begin
        shadow[pa] = pd;
        pend = 0;
      end
      if (state == 2'b00) shadow_defaults();  // R4 defaults whenever off
      bad = 0;
      for (int i = 0; i < NREG; i++)
        if (regs[i*DW +: DW] != shadow[i]) bad = i + 1;
      if (bad == 0) chk(1, "R7", "regs", 0, 0);
      else chk(0, "R7", $sformatf("reg%0d", bad - 1),
               regs[(bad-1)*DW +: DW], shadow[bad-1]);
      chk(state != 2'b11, "R10", "state code", state, 0);
      if (wr_stb) begin
        if (exp_q.size() == 0) chk(0, "R3", "unexpected strobe", wr_addr, 0);
        else begin
          logic [12:0] e;
          e = exp_q.pop_front();
          chk(wr_addr == e[12:8], "R6", "wr_addr", wr_addr, e[12:8]);
          chk(wr_data == e[7:0], "R7", "wr_data", wr_data, e[7:0]);
          pend = 1; pa = int'(wr_addr); pd = wr_data;
        end
      end
    end
  end

  task automatic lvl(input logic v, input int n);
    pin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int b, input logic [4:0] a, input logic [7:0] d,
                      input bit expect_wr);
    if (expect_wr) exp_q.push_back({a, d});
    lvl(0, b); lvl(1, b);            // wake pair
    lvl(0, b); lvl(1, b);            // measurement pair (R5)
    lvl(0, b);                       // start bit
    if (expect_wr) chk(state == 2'b10, "R9", "active mid-frame", state, 2);
    for (int i = 4; i >= 0; i--) lvl(a[i], b);
    for (int i = 7; i >= 0; i--) lvl(d[i], b);
    lvl(1, 6 * b);                   // guard, 5 bit times plus margin
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    pin = 1'b0; rst_n = 1'b0;
    shadow_defaults();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    chk(state == 2'b00, "R4", "reset state", state, 0);
    chk(regs[FLT_ADDR*DW +: DW] == 8'h01, "R4", "fault default", regs[FLT_ADDR*DW +: DW], 1);

    lvl(1, EN / 2);
    chk(state == 2'b00, "R1", "short high stays off", state, 0);
    lvl(1, EN / 2 + 20);
    chk(state == 2'b01, "R1", "sleep after long high", state, 1);

    send(24, 5'h12, 8'hA5, 1);
    chk(state == 2'b01, "R9", "sleep after guard", state, 1);
    send(40, 5'h00, 8'hFF, 1);       // R5 slower rate
    send(21, 5'h1F, 8'h01, 1);       // R5 near 20x limit
    send(30, 5'h01, 8'h00, 1);       // R7 clear fault bit
    send(24, 5'h0A, 8'h3C, 1);       // R6 address order
    chk(exp_q.size() == 0, "R8", "one strobe per frame", exp_q.size(), 0);
    chk(regs[FLT_ADDR*DW +: DW] == 8'h00, "R7", "fault written", regs[FLT_ADDR*DW +: DW], 0);

    lvl(0, DIS + 20);
    chk(state == 2'b00, "R2", "shutdown after long low", state, 0);
    chk(regs[FLT_ADDR*DW +: DW] == 8'h01, "R4", "fault restored", regs[FLT_ADDR*DW +: DW], 1);
    chk(regs[18*DW +: DW] == 8'h00, "R4", "reg18 cleared", regs[18*DW +: DW], 0);

    send(24, 5'h05, 8'h55, 0);       // R3 frame while disabled
    lvl(0, 10);
    chk(state == 2'b00, "R3", "still disabled", state, 0);
    chk(regs[5*DW +: DW] == 8'h00, "R3", "reg5 untouched", regs[5*DW +: DW], 0);

    lvl(1, EN + 20);
    chk(state == 2'b01, "R1", "re-enabled", state, 1);
    send(32, 5'h05, 8'h96, 1);
    chk(regs[5*DW +: DW] == 8'h96, "R7", "reg5 after re-enable", regs[5*DW +: DW], 8'h96);
    chk(exp_q.size() == 0, "R8", "all writes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule